// File: doc/BRIEF.md
# PCM Frame Serial Port

This block is the digital edge of a voice-band PCM port. Once per frame it moves one transmit word out on a serial line and one receive word in from a serial line. The bit clock and the frame sync come from outside. Both are sampled by a faster system clock and must be synchronous to it. A transmit bit changes on each rising edge of the bit clock and a receive bit is captured on each falling edge. Both words travel most significant bit first.

Control inputs choose the sync mode and the word format. In long mode the sync pulse spans the data. In short mode the sync pulse is one bit clock wide and comes one bit before the data. The word is either 8 bits companded or 14 bits of two's complement linear data. Two more inputs replace the transmit word or the receive word with an idle code, and a power-down input parks the serial line high. The transmit and receive datapaths attach through parallel word ports. The receive port carries a one-cycle valid strobe.

Top module: `pcm_frame_port`

## Requirements
- R1: After reset with power-down low, `sd_o` is low and `rx_valid_o` is low until a frame starts.
- R2: While `pwr_down_i` is high, `sd_o` is high, no frame starts and `rx_valid_o` stays low.
- R3: Long mode (`short_mode_i`=0): the first data bit is driven after the first bit-clock rising edge at which `fsync_i` is seen high after being low.
- R4: Short mode (`short_mode_i`=1): the first data bit is driven after the rising edge that follows the rising edge at which `fsync_i` was seen high.
- R5: The word is sent most significant bit first. It is `tx_word_i[7:0]` (8 bits) when `linear_i`=0 and `tx_word_i[13:0]` (14 bits) when `linear_i`=1.
- R6: Outside the data bits of a frame, with power-down low, `sd_o` is low.
- R7: The transmit word is latched at frame start. Later changes of `tx_word_i` in the same frame have no effect on `sd_o`.
- R8: With `coder_off_i`=1 at frame start, the line carries the idle code instead of the word. The idle code is 0xD5 when `alaw_i`=1, 0xFF when `alaw_i`=0, and 14 zero bits in linear mode.
- R9: Receive bits are captured on bit-clock falling edges during the data bits. After the last bit, `rx_word_o` is updated and `rx_valid_o` pulses for exactly one clock. A companded word appears in `rx_word_o[7:0]` with zeros above it.
- R10: Serial input bits that arrive after the last data bit of a frame do not change the received word, and they produce no second strobe in that frame.
- R11: With `decoder_off_i`=1 at frame start, the strobed receive word is the idle code defined in R8.
- R12: `linear_i`, `alaw_i`, `coder_off_i` and `decoder_off_i` are taken at frame start. A change later in the frame does not alter that frame's length or contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bit clock and the sync |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Bit clock, synchronous to clk |
| fsync_i | input | 1 | Frame sync |
| sd_i | input | 1 | Serial receive data |
| sd_o | output | 1 | Serial transmit data |
| short_mode_i | input | 1 | 1 selects short sync mode, 0 selects long |
| linear_i | input | 1 | 1 selects 14-bit linear words, 0 selects 8-bit companded |
| alaw_i | input | 1 | Companding law for the idle code: 1 A-law, 0 µ-law |
| coder_off_i | input | 1 | Send the idle code instead of the transmit word |
| decoder_off_i | input | 1 | Deliver the idle code instead of the received word |
| pwr_down_i | input | 1 | Power-down: line high, port halted |
| tx_word_i | input | 14 | Parallel transmit word |
| rx_word_o | output | 14 | Parallel receive word |
| rx_valid_o | output | 1 | One-cycle strobe for a new receive word |

## Verification
Two events can share one system clock cycle. The first is the last receive capture of a frame, which drives the strobe. The second is a change of the mode inputs or of the transmit word during that same frame. The bench changes `tx_word_i` and `linear_i` during the data window of every frame, so the latching at frame start is tested against live input changes. It then compares the serial bits and the strobed word with values computed from the configuration that held at frame start. In long mode the sync stays high past the last data bit, and the serial input keeps toggling after the last bit. Each frame must give exactly one strobe, and its word must be built from the data bits alone.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
  localparam int unsigned LIN_W = 14;
  localparam int unsigned CMP_W = 8;

  typedef struct packed {
    logic lin;
    logic alaw;
    logic dec_off;
  } frame_cfg_t;

  function automatic logic [LIN_W-1:0] idle_code(input logic lin, input logic alaw);
    if (lin) idle_code = '0;
    else if (alaw) idle_code = LIN_W'(8'hD5);
    else idle_code = LIN_W'(8'hFF);
  endfunction
endpackage

// File: rtl/pcm_frame_ctl.sv
module pcm_frame_ctl
  import pcm_port_pkg::*;
#(
  parameter int unsigned MAXW = LIN_W,
  parameter int unsigned MINW = CMP_W,
  localparam int unsigned CW = $clog2(MAXW)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bclk_i,
  input  logic       fsync_i,
  input  logic       short_i,
  input  logic       pd_i,
  input  frame_cfg_t cfg_i,
  output logic       start_o,
  output logic       shift_o,
  output logic       cap_o,
  output logic       last_o,
  output logic       active_o,
  output frame_cfg_t cfg_o
);
  localparam logic [CW-1:0] LAST_LIN = CW'(MAXW - 1);
  localparam logic [CW-1:0] LAST_CMP = CW'(MINW - 1);

  logic bclk_q, bclk_d;
  logic sync_q, sync_d;
  logic arm_q, arm_d;
  logic active_q, active_d;
  logic [CW-1:0] cnt_q, cnt_d;
  frame_cfg_t cfg_q, cfg_d;
  logic rise, fall, start, last;

  assign rise  = bclk_i & ~bclk_q;
  assign fall  = ~bclk_i & bclk_q;
  assign start = ~pd_i & rise & (short_i ? arm_q : (fsync_i & ~sync_q));
  assign last  = (cnt_q == (cfg_q.lin ? LAST_LIN : LAST_CMP));

  always_comb begin
    bclk_d   = bclk_i;
    sync_d   = sync_q;
    arm_d    = arm_q;
    active_d = active_q;
    cnt_d    = cnt_q;
    cfg_d    = cfg_q;
    if (pd_i) begin
      sync_d   = 1'b0;
      arm_d    = 1'b0;
      active_d = 1'b0;
      cnt_d    = '0;
    end else if (rise) begin
      sync_d = fsync_i;
      arm_d  = short_i & fsync_i;
      if (start) begin
        active_d = 1'b1;
        cnt_d    = '0;
        cfg_d    = cfg_i;
      end else if (active_q) begin
        if (last) active_d = 1'b0;
        else cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q   <= 1'b0;
      sync_q   <= 1'b0;
      arm_q    <= 1'b0;
      active_q <= 1'b0;
      cnt_q    <= '0;
      cfg_q    <= '0;
    end else begin
      bclk_q   <= bclk_d;
      sync_q   <= sync_d;
      arm_q    <= arm_d;
      active_q <= active_d;
      cnt_q    <= cnt_d;
      cfg_q    <= cfg_d;
    end
  end

  assign start_o  = start;
  assign shift_o  = ~pd_i & rise & active_q & ~last & ~start;
  assign cap_o    = ~pd_i & fall & active_q;
  assign last_o   = last;
  assign active_o = active_q;
  assign cfg_o    = cfg_q;

  // R2: power-down closes any open frame on the next cycle
  p_pd_halts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pd_i |=> !active_q);
  // R3: a frame start opens the window at bit zero
  p_start_opens_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (active_q && cnt_q == '0));
  // R5: the bit counter never passes the word length latched for the frame
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (cnt_q <= (cfg_q.lin ? LAST_LIN : LAST_CMP)));
endmodule

// File: rtl/pcm_tx_shift.sv
module pcm_tx_shift
  import pcm_port_pkg::*;
#(
  parameter int unsigned MAXW = LIN_W,
  parameter int unsigned MINW = CMP_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic            shift_i,
  input  logic            active_i,
  input  logic            pd_i,
  input  logic            lin_i,
  input  logic            alaw_i,
  input  logic            coder_off_i,
  input  logic [MAXW-1:0] word_i,
  output logic            sd_o
);
  localparam int unsigned PAD = MAXW - MINW;

  logic [MAXW-1:0] sh_q, sh_d, src;

  always_comb begin
    src = coder_off_i ? idle_code(lin_i, alaw_i) : word_i;
    sh_d = sh_q;
    if (load_i) begin
      if (lin_i) sh_d = src;
      else sh_d = {src[MINW-1:0], {PAD{1'b0}}};
    end else if (shift_i) begin
      sh_d = {sh_q[MAXW-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else sh_q <= sh_d;
  end

  assign sd_o = pd_i | (active_i & sh_q[MAXW-1]);
endmodule

// File: rtl/pcm_rx_shift.sv
module pcm_rx_shift
  import pcm_port_pkg::*;
#(
  parameter int unsigned MAXW = LIN_W,
  parameter int unsigned MINW = CMP_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap_i,
  input  logic            last_i,
  input  logic            sd_i,
  input  frame_cfg_t      cfg_i,
  output logic [MAXW-1:0] word_o,
  output logic            valid_o
);
  localparam int unsigned PAD = MAXW - MINW;

  logic [MAXW-1:0] sr_q, sr_d, word_q, word_d, full;
  logic valid_q, valid_d;

  always_comb begin
    sr_d    = sr_q;
    word_d  = word_q;
    valid_d = 1'b0;
    full    = {sr_q[MAXW-2:0], sd_i};
    if (cap_i) begin
      sr_d = full;
      if (last_i) begin
        valid_d = 1'b1;
        if (cfg_i.dec_off) word_d = idle_code(cfg_i.lin, cfg_i.alaw);
        else if (cfg_i.lin) word_d = full;
        else word_d = {{PAD{1'b0}}, full[MINW-1:0]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q    <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      sr_q    <= sr_d;
      word_q  <= word_d;
      valid_q <= valid_d;
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;

  // R9: the receive strobe lasts a single clock
  p_strobe_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);
  // R9: a companded word carries zeros above its eight bits
  p_cmp_pad_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !$past(cfg_i.lin)) |-> (word_q[MAXW-1:MINW] == '0));
endmodule

// File: rtl/pcm_frame_port.sv
module pcm_frame_port
  import pcm_port_pkg::*;
#(
  parameter int unsigned MAXW = LIN_W,
  parameter int unsigned MINW = CMP_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bclk_i,
  input  logic            fsync_i,
  input  logic            sd_i,
  output logic            sd_o,
  input  logic            short_mode_i,
  input  logic            linear_i,
  input  logic            alaw_i,
  input  logic            coder_off_i,
  input  logic            decoder_off_i,
  input  logic            pwr_down_i,
  input  logic [MAXW-1:0] tx_word_i,
  output logic [MAXW-1:0] rx_word_o,
  output logic            rx_valid_o
);
  frame_cfg_t cfg_in, cfg_q;
  logic start, shift, cap, last, active;

  assign cfg_in = '{lin: linear_i, alaw: alaw_i, dec_off: decoder_off_i};

  pcm_frame_ctl #(.MAXW(MAXW), .MINW(MINW)) u_ctl (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk_i), .fsync_i(fsync_i),
    .short_i(short_mode_i), .pd_i(pwr_down_i), .cfg_i(cfg_in),
    .start_o(start), .shift_o(shift), .cap_o(cap), .last_o(last),
    .active_o(active), .cfg_o(cfg_q)
  );

  pcm_tx_shift #(.MAXW(MAXW), .MINW(MINW)) u_tx (
    .clk(clk), .rst_n(rst_n), .load_i(start), .shift_i(shift),
    .active_i(active), .pd_i(pwr_down_i), .lin_i(linear_i),
    .alaw_i(alaw_i), .coder_off_i(coder_off_i), .word_i(tx_word_i),
    .sd_o(sd_o)
  );

  pcm_rx_shift #(.MAXW(MAXW), .MINW(MINW)) u_rx (
    .clk(clk), .rst_n(rst_n), .cap_i(cap), .last_i(last), .sd_i(sd_i),
    .cfg_i(cfg_q), .word_o(rx_word_o), .valid_o(rx_valid_o)
  );

  // R6: with no window open and power on, the line rests low
  p_quiet_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_down_i && !active) |-> !sd_o);
  // R2: no receive strobe is raised while powered down
  p_pd_no_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pwr_down_i) |-> !rx_valid_o);
endmodule

// File: tb/pcm_frame_port_tb.sv
module pcm_frame_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NPER = 20;
  localparam int W = 14;

  logic clk = 1'b0;
  logic rst_n, bclk, fsync, sdi, sdo;
  logic short_m, lin, alaw, coff, doff, pd;
  logic [W-1:0] txw, rxw;
  logic rxv;

  int checks = 0;
  int fails = 0;
  int vcount = 0;
  logic [W-1:0] vword;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcm_frame_port dut_i (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .fsync_i(fsync), .sd_i(sdi),
    .sd_o(sdo), .short_mode_i(short_m), .linear_i(lin), .alaw_i(alaw),
    .coder_off_i(coff), .decoder_off_i(doff), .pwr_down_i(pd),
    .tx_word_i(txw), .rx_word_o(rxw), .rx_valid_o(rxv)
  );

  always @(negedge clk) if (rxv) begin
    vcount++;
    vword = rxw;
  end

  function automatic logic [W-1:0] idle_of(input logic l, input logic a);
    if (l) return '0;
    return a ? W'(8'hD5) : W'(8'hFF);
  endfunction

  // expected line bits, left aligned
  function automatic logic [W-1:0] tx_bits(input logic [W-1:0] w, input logic l,
                                           input logic a, input logic c);
    logic [W-1:0] s;
    s = c ? idle_of(l, a) : w;
    if (l) return s;
    return {s[7:0], 6'b0};
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one frame of NPER bit periods; configuration held in the module signals
  task automatic run_frame(input logic [W-1:0] word, input logic [NPER-1:0] rxbits,
                           input logic flip_lin, input string req);
    logic l0, a0, c0, d0, s0;
    int wl, off;
    logic [W-1:0] exp_tx, exp_rx;
    logic [NPER-1:0] seen;
    int bad;
    l0 = lin; a0 = alaw; c0 = coff; d0 = doff; s0 = short_m;
    wl = l0 ? 14 : 8;
    off = s0 ? 1 : 0;
    exp_tx = tx_bits(word, l0, a0, c0);
    exp_rx = '0;
    for (int j = 0; j < wl; j++) exp_rx = {exp_rx[W-2:0], rxbits[j+off]};
    if (d0) exp_rx = idle_of(l0, a0);
    txw = word;
    vcount = 0;
    bad = 0;
    for (int k = 0; k < NPER; k++) begin
      bclk = 1'b1;
      fsync = s0 ? (k == 0) : (k < wl + 2);
      wait_neg(2);
      seen[k] = sdo;
      sdi = rxbits[k];
      if (k == 2) begin
        txw = ~word;
        if (flip_lin) lin = ~lin;
      end
      wait_neg(2);
      bclk = 1'b0;
      wait_neg(4);
    end
    lin = l0;
    for (int k = 0; k < NPER; k++) begin
      logic e;
      if (pd) e = 1'b1;
      else if (k >= off && k < off + wl) e = exp_tx[W-1-(k-off)];
      else e = 1'b0;
      if (seen[k] !== e) bad++;
    end
    if (pd) begin
      check({req, " R2 line high"}, W'(bad), '0);
      check("R2 no strobe", W'(vcount), '0);
    end else begin
      check({req, " R5 R6 R7 tx bits"}, W'(bad), '0);
      check({req, " R10 strobe count"}, W'(vcount), W'(1));
      check({req, " R9 rx word"}, vword, exp_rx);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    rst_n = 0; bclk = 0; fsync = 0; sdi = 0;
    short_m = 0; lin = 0; alaw = 0; coff = 0; doff = 0; pd = 0; txw = '0;
    wait_neg(4);
    rst_n = 1;
    wait_neg(4);
    check("R1 line low after reset", W'(sdo), '0);
    check("R1 no strobe after reset", W'(rxv), '0);

    // R3 long mode, companded
    run_frame(14'h00A5, 20'hA5C3F, 0, "R3 long cmp");
    // R4 short mode, linear
    short_m = 1; lin = 1;
    run_frame(14'h2B6D, 20'h5A3C1, 0, "R4 short lin");
    // R8 coder idle codes
    short_m = 0; coff = 1;
    lin = 0; alaw = 1; run_frame(14'h0011, 20'hFFFFF, 0, "R8 A-law idle");
    lin = 0; alaw = 0; run_frame(14'h0000, 20'h00000, 0, "R8 mu-law idle");
    lin = 1;            run_frame(14'h3FFF, 20'h12345, 0, "R8 linear idle");
    coff = 0;
    // R11 decoder idle
    doff = 1; lin = 0; alaw = 1;
    run_frame(14'h0042, 20'h0F0F0, 0, "R11 A-law dec idle");
    alaw = 0; short_m = 1;
    run_frame(14'h0042, 20'h0F0F0, 0, "R11 mu-law dec idle");
    doff = 0;
    // R12 word length flip mid-frame
    lin = 0; short_m = 0;
    run_frame(14'h00C3, 20'hFFF00, 1, "R12 cmp flip");
    lin = 1; short_m = 1;
    run_frame(14'h1234, 20'hAAAAA, 1, "R12 lin flip");
    // R2 power-down
    pd = 1;
    run_frame(14'h1FFF, 20'h55555, 0, "R2 pd");
    pd = 0;
    // random frames
    for (int n = 0; n < 24; n++) begin
      short_m = 1'($urandom);
      lin = 1'($urandom);
      alaw = 1'($urandom);
      coff = (($urandom % 5) == 0);
      doff = (($urandom % 5) == 0);
      run_frame(14'($urandom), 20'($urandom), 1'($urandom), "rand");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule